// File: doc/BRIEF.md
# Synchronous Serial Master Transmitter

This block is the transmit side of a clocked serial port that owns the bus clock. A host places a data byte into a one-entry holding buffer. Along with the byte it gives a word-length select and, for long words, an extra ninth bit. When the shift stage is free, the word moves into it. The word is then sent least-significant bit first on the data line, while the block drives the serial clock from an 8-bit programmable divider.

The host sees two status outputs. The first is a buffer-empty flag, which also drives a maskable interrupt request; it tells the host when the buffer can take the next word. The second is a shift-empty status bit with no interrupt attached. The port is half-duplex. While a word is pending or being shifted, the block raises a receive-inhibit output. While the receive side reports activity, no new word is started. If the transmit enable is dropped, all pending and in-flight data is discarded.

Top module: `sync_tx_master`

## Requirements
- R1: After reset, buf_empty=1, shift_empty=1, ser_clk=0, ser_dat=0, irq=0 and rx_inhibit=0.
- R2: pins_active is port_en AND sync_mode AND clk_master. A word is accepted and shifted only while pins_active and tx_en are both 1. A write made at any other time is dropped.
- R3: Bits go out least-significant first. ser_dat changes only when ser_clk rises and holds while ser_clk is high. Each clock half-period lasts div+1 cycles. The first rise comes div+1 cycles after the word enters the shift stage, which is two cycles after the write.
- R4: With wr_nine=1, the word is 9 bits long: the 8 data bits first, then wr_ninth. wr_nine and wr_ninth are captured with the write.
- R5: A write is taken only while the holding buffer is empty. A write made while the buffer holds a word is ignored and never sent.
- R6: The shift stage takes the buffered word when the stage is idle. It also takes it on the falling clock edge that ends the last bit, so the next rise follows div+1 cycles later with no gap.
- R7: buf_empty stays 1 in the cycle after the write edge and is 0 from the second edge on. It returns to 1 one cycle after the word leaves the buffer. Nothing but a write clears it.
- R8: irq is 1 exactly when buf_empty and irq_en are both 1.
- R9: shift_empty is 1 whenever the shift stage holds no word. In that case ser_clk and ser_dat are 0.
- R10: rx_inhibit is 1 while a word sits in the buffer or the shift stage. While rx_busy is 1, an idle shift stage starts no word.
- R11: When tx_en falls, on the next cycle the shift stage and the buffer are empty and ser_clk and ser_dat are 0. buf_empty rises one cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Serial port enable |
| sync_mode | input | 1 | Synchronous mode select |
| clk_master | input | 1 | Block sources the serial clock |
| tx_en | input | 1 | Transmit enable; clearing aborts |
| irq_en | input | 1 | Interrupt mask for buffer-empty |
| div | input | 8 | Rate divisor; half-period is div+1 cycles |
| wr_valid | input | 1 | Host write strobe |
| wr_data | input | 8 | Data byte to send |
| wr_nine | input | 1 | 1 selects a 9-bit word |
| wr_ninth | input | 1 | Ninth bit for 9-bit words |
| rx_busy | input | 1 | Receive side active; holds off starts |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_dat | output | 1 | Serial data |
| pins_active | output | 1 | Port pins in master synchronous use |
| buf_empty | output | 1 | Holding buffer empty flag |
| irq | output | 1 | Buffer-empty interrupt request |
| shift_empty | output | 1 | Shift stage empty status |
| rx_inhibit | output | 1 | Receive must be held off |

## Verification
The hardest case to reach from the ports is the hand-over at the end of a word. The buffer must already hold the next word at the moment the final falling clock edge ends the last bit. On top of that, a third write must arrive while the buffer is still full, so that the drop can be observed. The stimulus writes a second word as soon as the first has moved into the shift stage, then writes a third word at once. The bench then checks that exactly sixteen bits leave with uniform half-periods across the word boundary, and that the third word never appears. The abort is reached by dropping tx_en partway through a word while another word is buffered.

// File: rtl/stx_pkg.sv
package stx_pkg;
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;
endpackage

// File: rtl/stx_rate_div.sv
module stx_rate_div #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = run && (st_q.cnt == div);
        if (!run || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/stx_holding.sv
module stx_holding #(
    parameter int unsigned HW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          wr_valid,
    input  logic [HW-1:0] wr_word,
    input  logic          take,
    output logic          full,
    output logic [HW-1:0] word,
    output logic          empty_flag
);
    typedef struct packed {
        logic          full;
        logic [HW-1:0] word;
        logic          flag;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        // flag follows occupancy one cycle late
        st_d.flag = ~st_q.full;
        if (!enable) begin
            st_d.full = 1'b0;
        end else if (take) begin
            st_d.full = 1'b0;
        end else if (wr_valid && !st_q.full) begin
            st_d.full = 1'b1;
            st_d.word = wr_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.flag <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign full       = st_q.full;
    assign word       = st_q.word;
    assign empty_flag = st_q.flag;
endmodule

// File: rtl/stx_shifter.sv
module stx_shifter
    import stx_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tick,
    input  logic              load_ok,
    input  logic [DATA_W+1:0] load_word,
    output logic              take,
    output logic              busy,
    output logic              ser_clk,
    output logic              ser_dat
);
    localparam int unsigned LW = $clog2(DATA_W + 2);

    typedef struct packed {
        logic            busy;
        phase_e          phase;
        logic [DATA_W:0] sreg;
        logic [LW-1:0]   left;
        logic            sclk;
        logic            sdat;
    } st_t;

    st_t st_d, st_q;

    function automatic st_t start_word(input logic [DATA_W+1:0] w);
        st_t s;
        s       = '0;
        s.busy  = 1'b1;
        s.phase = PH_LOW;
        s.sreg  = w[DATA_W:0];
        s.left  = w[DATA_W+1] ? LW'(DATA_W + 1) : LW'(DATA_W);
        return s;
    endfunction

    always_comb begin
        st_d = st_q;
        take = 1'b0;
        if (!enable) begin
            st_d = '0;
        end else if (!st_q.busy) begin
            if (load_ok) begin
                take = 1'b1;
                st_d = start_word(load_word);
            end
        end else if (tick) begin
            if (st_q.phase == PH_LOW) begin
                st_d.sclk  = 1'b1;
                st_d.sdat  = st_q.sreg[0];
                st_d.sreg  = st_q.sreg >> 1;
                st_d.left  = st_q.left - 1'b1;
                st_d.phase = PH_HIGH;
            end else begin
                st_d.sclk  = 1'b0;
                st_d.phase = PH_LOW;
                if (st_q.left == '0) begin
                    if (load_ok) begin
                        take = 1'b1;
                        st_d = start_word(load_word);
                    end else begin
                        st_d.busy = 1'b0;
                        st_d.sdat = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = st_q.busy;
    assign ser_clk = st_q.sclk;
    assign ser_dat = st_q.sdat;
endmodule

// File: rtl/sync_tx_master.sv
module sync_tx_master #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic              sync_mode,
    input  logic              clk_master,
    input  logic              tx_en,
    input  logic              irq_en,
    input  logic [DIV_W-1:0]  div,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_nine,
    input  logic              wr_ninth,
    input  logic              rx_busy,
    output logic              ser_clk,
    output logic              ser_dat,
    output logic              pins_active,
    output logic              buf_empty,
    output logic              irq,
    output logic              shift_empty,
    output logic              rx_inhibit
);
    localparam int unsigned HW = DATA_W + 2;

    logic          run;
    logic          tick;
    logic          take;
    logic          hold_full;
    logic [HW-1:0] hold_word;
    logic          sh_busy;

    assign pins_active = port_en & sync_mode & clk_master;
    assign run         = pins_active & tx_en;

    stx_rate_div #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (sh_busy),
        .div   (div),
        .tick  (tick)
    );

    stx_holding #(.HW(HW)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (run),
        .wr_valid   (wr_valid),
        .wr_word    ({wr_nine, wr_ninth, wr_data}),
        .take       (take),
        .full       (hold_full),
        .word       (hold_word),
        .empty_flag (buf_empty)
    );

    stx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (run),
        .tick      (tick),
        .load_ok   (hold_full & ~rx_busy),
        .load_word (hold_word),
        .take      (take),
        .busy      (sh_busy),
        .ser_clk   (ser_clk),
        .ser_dat   (ser_dat)
    );

    assign shift_empty = ~sh_busy;
    assign rx_inhibit  = sh_busy | hold_full;
    assign irq         = buf_empty & irq_en;
endmodule

// File: rtl/stx_checker.sv
module stx_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic irq_en,
    input logic rx_busy,
    input logic ser_clk,
    input logic ser_dat,
    input logic pins_active,
    input logic buf_empty,
    input logic irq,
    input logic shift_empty,
    input logic rx_inhibit
);
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        shift_empty |-> (!ser_clk && !ser_dat));

    p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (shift_empty && !rx_inhibit));

    p_pins_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pins_active |=> shift_empty);

    p_rx_holdoff_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_empty && rx_busy) |=> shift_empty);

    p_half_duplex_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_empty |-> rx_inhibit);

    p_irq_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (buf_empty && irq_en));

    p_dat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_dat));
endmodule

bind sync_tx_master stx_checker u_chk (.*);

// File: tb/sync_tx_master_tb.sv
module sync_tx_master_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_en = 1'b1, sync_mode = 1'b1, clk_master = 1'b1;
    logic       tx_en = 1'b1, irq_en = 1'b0;
    logic [7:0] div = 8'd0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       wr_nine = 1'b0, wr_ninth = 1'b0, rx_busy = 1'b0;
    logic       ser_clk, ser_dat, pins_active, buf_empty, irq, shift_empty, rx_inhibit;

    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    sync_tx_master u_dut (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .sync_mode(sync_mode),
        .clk_master(clk_master), .tx_en(tx_en), .irq_en(irq_en), .div(div),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_nine(wr_nine),
        .wr_ninth(wr_ninth), .rx_busy(rx_busy), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .pins_active(pins_active), .buf_empty(buf_empty),
        .irq(irq), .shift_empty(shift_empty), .rx_inhibit(rx_inhibit)
    );

    // serial line monitor, evaluated at falling system clock
    int          cyc = 0;
    logic        mon_clr = 1'b1;
    logic        prev_clk = 1'b0;
    logic [63:0] cap;
    int          ncap, hp_min, hp_max, last_t, first_rise;
    bit          have_t;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (mon_clr) begin
            cap = '0; ncap = 0; hp_min = 9999; hp_max = 0;
            have_t = 1'b0; first_rise = -1;
        end else if (ser_clk != prev_clk) begin
            if (have_t) begin
                if (cyc - last_t < hp_min) hp_min = cyc - last_t;
                if (cyc - last_t > hp_max) hp_max = cyc - last_t;
            end
            have_t = 1'b1;
            last_t = cyc;
            if (ser_clk) begin
                if (ncap < 64) cap[ncap] = ser_dat;
                if (first_rise < 0) first_rise = cyc;
                ncap = ncap + 1;
            end
        end
        prev_clk = ser_clk;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_mon();
        @(negedge clk); #1 mon_clr = 1'b1;
        @(negedge clk); #1 mon_clr = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d, input logic nine, input logic ninth, output int w);
        @(negedge clk);
        #1;
        wr_valid = 1'b1; wr_data = d; wr_nine = nine; wr_ninth = ninth;
        w = cyc;
        @(negedge clk);
        #1 wr_valid = 1'b0;
    endtask

    task automatic wait_done();
        idle(3);
        while (!shift_empty) @(negedge clk);
        idle(1);
    endtask

    typedef struct packed {
        logic [7:0] dv;
        logic       nine;
        logic       ninth;
        logic [7:0] data;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{8'd0, 1'b0, 1'b0, 8'hA5},
        '{8'd1, 1'b1, 1'b1, 8'h3C},
        '{8'd2, 1'b0, 1'b1, 8'h81},
        '{8'd0, 1'b1, 1'b0, 8'hFF},
        '{8'd3, 1'b1, 1'b1, 8'h00},
        '{8'd5, 1'b0, 1'b0, 8'h6E}
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        int w;
        int bits;
        logic [8:0] expw;
        idle(2);
        // R1 reset state
        chk(buf_empty == 1'b1, "R1 buf_empty", buf_empty, 1);
        chk(shift_empty == 1'b1 && ser_clk == 1'b0 && ser_dat == 1'b0, "R1 serial idle",
            {shift_empty, ser_clk, ser_dat}, 3'b100);
        chk(irq == 1'b0 && rx_inhibit == 1'b0, "R1 irq/rx_inhibit", {irq, rx_inhibit}, 0);
        #1 rst_n = 1'b1;
        clear_mon();

        // vector walk: R3 R4
        foreach (VECS[i]) begin
            div = VECS[i].dv;
            clear_mon();
            wr(VECS[i].data, VECS[i].nine, VECS[i].ninth, w);
            wait_done();
            bits = VECS[i].nine ? 9 : 8;
            expw = VECS[i].nine ? {VECS[i].ninth, VECS[i].data} : {1'b0, VECS[i].data};
            chk(ncap == bits, "R4 bit count", ncap, bits);
            chk(cap[8:0] == expw, "R3 R4 word lsb first", cap[8:0], expw);
            chk(hp_min == VECS[i].dv + 1 && hp_max == VECS[i].dv + 1, "R3 half period",
                hp_max, VECS[i].dv + 1);
            chk(first_rise == w + VECS[i].dv + 3, "R3 first rise", first_rise - w, VECS[i].dv + 3);
        end

        // R7 R8 flag lag and interrupt gating
        div = 8'd3;
        idle(2);
        chk(irq == 1'b0, "R8 masked irq", irq, 0);
        irq_en = 1'b1;
        idle(1);
        chk(irq == 1'b1, "R8 irq when empty", irq, 1);
        clear_mon();
        wr(8'h11, 1'b0, 1'b0, w);
        chk(buf_empty == 1'b1, "R7 flag lag first cycle", buf_empty, 1);
        idle(1);
        chk(buf_empty == 1'b0 && irq == 1'b0, "R7 flag low second cycle", buf_empty, 0);
        chk(shift_empty == 1'b0, "R9 shift busy", shift_empty, 0);
        idle(1);
        chk(buf_empty == 1'b1 && irq == 1'b1, "R7 flag back after transfer", buf_empty, 1);
        wait_done();
        chk(cap[7:0] == 8'h11, "R3 word", cap[7:0], 8'h11);
        irq_en = 1'b0;

        // R5 R6 back-to-back with dropped third write
        div = 8'd1;
        clear_mon();
        wr(8'hC3, 1'b0, 1'b0, w);
        wr(8'h5A, 1'b0, 1'b0, w);
        wr(8'hEE, 1'b0, 1'b0, w);
        chk(buf_empty == 1'b0, "R7 flag held while full", buf_empty, 0);
        chk(rx_inhibit == 1'b1, "R10 inhibit during send", rx_inhibit, 1);
        wait_done();
        chk(ncap == 16, "R5 only two words", ncap, 16);
        chk(cap[15:0] == 16'h5AC3, "R5 R6 words in order", cap[15:0], 16'h5AC3);
        chk(hp_min == 2 && hp_max == 2, "R6 no gap between words", hp_max, 2);

        // R10 receive activity holds off start
        rx_busy = 1'b1;
        clear_mon();
        wr(8'h96, 1'b0, 1'b0, w);
        idle(20);
        chk(shift_empty == 1'b1 && ncap == 0, "R10 start held", ncap, 0);
        chk(rx_inhibit == 1'b1, "R10 inhibit with buffered word", rx_inhibit, 1);
        rx_busy = 1'b0;
        wait_done();
        chk(ncap == 8 && cap[7:0] == 8'h96, "R10 sent after release", cap[7:0], 8'h96);

        // R11 abort
        div = 8'd3;
        clear_mon();
        wr(8'hF0, 1'b0, 1'b0, w);
        wr(8'h0F, 1'b0, 1'b0, w);
        idle(6);
        @(negedge clk); #1 tx_en = 1'b0;
        @(negedge clk);
        chk(shift_empty && !ser_clk && !ser_dat && !rx_inhibit, "R11 abort clears",
            {shift_empty, ser_clk, ser_dat, rx_inhibit}, 4'b1000);
        chk(buf_empty == 1'b0, "R11 flag lag after abort", buf_empty, 0);
        idle(1);
        chk(buf_empty == 1'b1, "R11 flag set after abort", buf_empty, 1);
        #1 tx_en = 1'b1;
        clear_mon();
        idle(30);
        chk(ncap == 0 && shift_empty, "R11 buffered word discarded", ncap, 0);

        // R2 pin gating and dropped write
        port_en = 1'b0;
        idle(1);
        chk(pins_active == 1'b0, "R2 pins inactive", pins_active, 0);
        clear_mon();
        wr(8'h77, 1'b0, 1'b0, w);
        idle(3);
        chk(buf_empty == 1'b1 && rx_inhibit == 1'b0, "R2 write dropped", buf_empty, 1);
        #1 port_en = 1'b1;
        idle(1);
        chk(pins_active == 1'b1, "R2 pins active", pins_active, 1);
        idle(30);
        chk(ncap == 0, "R2 nothing sent", ncap, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule